// File: doc/BRIEF.md
# Serial Byte Transmitter with Divisor-Latch Register Bank

This block sends bytes as asynchronous serial frames on a single output line. A CPU reaches it over an 8-bit I/O bus through four byte-wide registers. The registers are a data slot, a divisor latch split across two offsets, a line setup register, and a status register that tells software when the next byte may be written. The block keeps one byte waiting at a time. It has no queue and no flow control. Software polls one status bit before every write.

Bit 7 of the line setup register changes what offsets 0 and 1 mean. With the bit set, those offsets reach the low and high bytes of the 16-bit divisor. With the bit clear, offset 0 is the transmit data slot. Each serial bit lasts the divisor multiplied by an oversampling factor, counted in clock cycles; the factor defaults to 16. For example, a divisor of 833 on a 4 MHz clock gives 300 baud. Setup value 03h gives eight data bits, no parity and one stop bit.

Top module: `uart_tx_lite`

## Requirements
- R1: After reset the line `txd` is high, status reads 20h, line setup reads 00h and the divisor is 0000h.
- R2: While line setup bit 7 is 1, a write to offset 0 or 1 sets the divisor low or high byte, and a read of that offset returns the byte.
- R3: While line setup bit 7 is 0, a write to offset 0 loads the transmit slot, a write to offset 1 changes nothing, and a read of offset 0 or 1 returns 00h.
- R4: Status (offset 5) bit 5 reads 0 from the cycle after a data write until the byte enters the shifter, and reads 1 otherwise. All other status bits read 0. Offset 3 reads back the last value written to it.
- R5: A frame is a low start bit, then 5 + setup[1:0] data bits, LSB first, then one high stop bit. The line is high between frames, and setup 03h gives 8 data bits.
- R6: Every bit lasts OVERSAMPLE × divisor clock cycles. The start bit begins at the second rising edge after the edge that samples a data write to an idle block.
- R7: A divisor of 0 acts as 65536, and the frame still advances.
- R8: A byte written during a frame waits and starts right as the stop bit ends, with no idle gap. A second write before that point replaces the waiting byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register bank selected |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, 00h when not selected |
| txd | output | 1 | Serial output, high when idle |

## Verification
Register reads are combinational. The bench samples them one time step after setting the address at a falling edge. The status bit falls right after the write edge and rises one cycle later, at the load edge. Because of this the bench reads status once before and once after that next edge. The first falling edge that shows the start bit marks offset 0 for the frame. Bit k is then sampled at k·B + B/2 falling edges from that mark, where B = OVERSAMPLE × divisor. The edges of a bit are probed at B − 1 and B. A back-to-back byte is probed at exactly (n+2)·B. The divisor-zero case runs on a second instance with an oversampling factor of 1, so that its start bit lasts exactly 65536 cycles.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   localparam int OFS_DATA  = 0;
   localparam int OFS_DIVHI = 1;
   localparam int OFS_LINE  = 3;
   localparam int OFS_STAT  = 5;
   localparam int LINE_DLAB = 7;
   localparam int STAT_THRE = 5;
   localparam int WLEN_BASE = 5;

   typedef struct packed {
      logic       dlab;
      logic [4:0] spare;
      logic [1:0] wlen;
   } line_ctl_t;
endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
   import uart_tx_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel,
   input  logic                  wr,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  load,
   output logic [DATA_W-1:0]     rdata,
   output logic [DATA_W-1:0]     hold_data,
   output logic                  hold_full,
   output logic [2*DATA_W-1:0]   divisor,
   output logic [1:0]            wlen
);
   line_ctl_t         lcr;
   logic [DATA_W-1:0] dll;
   logic [DATA_W-1:0] dlm;

   logic wr_en, hit_lo, hit_hi, hit_line;
   assign wr_en    = sel && wr;
   assign hit_lo   = wr_en && (addr == ADDR_W'(OFS_DATA));
   assign hit_hi   = wr_en && (addr == ADDR_W'(OFS_DIVHI));
   assign hit_line = wr_en && (addr == ADDR_W'(OFS_LINE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr       <= '0;
         dll       <= '0;
         dlm       <= '0;
         hold_data <= '0;
         hold_full <= 1'b0;
      end else begin
         if (hit_lo && lcr.dlab)  dll       <= wdata;
         if (hit_lo && !lcr.dlab) hold_data <= wdata;
         if (hit_hi && lcr.dlab)  dlm       <= wdata;
         if (hit_line)            lcr       <= line_ctl_t'(wdata);
         if (hit_lo && !lcr.dlab) hold_full <= 1'b1;
         else if (load)           hold_full <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         case (addr)
            ADDR_W'(OFS_DATA):  if (lcr.dlab) rdata = dll;
            ADDR_W'(OFS_DIVHI): if (lcr.dlab) rdata = dlm;
            ADDR_W'(OFS_LINE):  rdata = lcr;
            ADDR_W'(OFS_STAT):  rdata[STAT_THRE] = !hold_full;
            default:            rdata = '0;
         endcase
      end
   end

   assign divisor = {dlm, dll};
   assign wlen    = lcr.wlen;
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last;

   // zero wraps to all-ones, which yields a period of 2**DIV_W
   assign last = divisor - DIV_W'(1);
   assign tick = run && (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || tick)  cnt <= '0;
      else                    cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
   import uart_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   input  logic [1:0]        wlen,
   output logic              load,
   output logic              busy,
   output logic              txd
);
   localparam int IDX_W = $clog2(DATA_W + 3);
   localparam int SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  n_bits;
   logic [1:0]        wlen_q;
   logic [DATA_W-1:0] sh;
   logic              bit_end;
   logic              frame_end;

   generate
      if (OVERSAMPLE == 1) begin : g_direct
         assign bit_end = tick;
      end else begin : g_sub
         logic [SUB_W-1:0] sub;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sub <= '0;
            else if (!busy) sub <= '0;
            else if (tick)  sub <= (sub == SUB_W'(OVERSAMPLE - 1)) ? '0 : sub + SUB_W'(1);
         end
         assign bit_end = tick && (sub == SUB_W'(OVERSAMPLE - 1));
      end
   endgenerate

   assign n_bits    = IDX_W'(WLEN_BASE) + IDX_W'(wlen_q);
   assign frame_end = bit_end && (idx == n_bits + IDX_W'(1));
   assign load      = hold_full && (!busy || frame_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         txd    <= 1'b1;
         idx    <= '0;
         sh     <= '0;
         wlen_q <= '0;
      end else if (load) begin
         busy   <= 1'b1;
         txd    <= 1'b0;
         idx    <= '0;
         sh     <= hold_data;
         wlen_q <= wlen;
      end else if (frame_end) begin
         busy <= 1'b0;
         txd  <= 1'b1;
      end else if (bit_end) begin
         idx <= idx + IDX_W'(1);
         if (idx < n_bits) begin
            txd <= sh[0];
            sh  <= sh >> 1;
         end else begin
            txd <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_tx_lite.sv
module uart_tx_lite #(
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              txd
);
   localparam int DIV_W = 2 * DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("uart_tx_lite: register layout needs DATA_W == 8");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("uart_tx_lite: ADDR_W must reach offset 5");
      end
      if (OVERSAMPLE < 1) begin : g_bad_ovs
         $error("uart_tx_lite: OVERSAMPLE must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] hold_data;
   logic              hold_full;
   logic [DIV_W-1:0]  divisor;
   logic [1:0]        wlen;
   logic              load;
   logic              busy;
   logic              tick;

   uart_tx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .load(load), .rdata(bus_rdata), .hold_data(hold_data),
      .hold_full(hold_full), .divisor(divisor), .wlen(wlen)
   );

   uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(busy), .divisor(divisor), .tick(tick)
   );

   uart_tx_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(hold_full),
      .hold_data(hold_data), .wlen(wlen), .load(load), .busy(busy), .txd(txd)
   );
endmodule

// File: rtl/uart_tx_lite_chk.sv
module uart_tx_lite_chk
   import uart_tx_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              txd,
   input logic              busy,
   input logic              tick,
   input logic              hold_full,
   input logic              load
);
   logic data_wr;
   assign data_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DATA));

   // R4
   thre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_full) |-> $past(data_wr));

   // R4
   thre_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load && !data_wr |=> !hold_full);

   // R5
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R5
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !txd && busy);

   // R6
   line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !tick |=> $stable(txd));

   // R8
   byte_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && hold_full && !tick |=> hold_full);
endmodule

bind uart_tx_lite uart_tx_lite_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .txd(txd), .busy(busy), .tick(tick),
   .hold_full(hold_full), .load(load)
);

// File: tb/test_uart_tx_lite.sv
module test_uart_tx_lite;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_a = 1'b0;
   logic       sel_z = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] rdata_a, rdata_z;
   logic       txd_a, txd_z;
   int         checks = 0;
   int         errors = 0;
   int unsigned cyc = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uart_tx_lite i_uart_tx_lite (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .txd(txd_a)
   );

   uart_tx_lite #(.OVERSAMPLE(1)) i_uart_tx_lite_z (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel_z), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_z), .txd(txd_z)
   );

   function automatic logic exp_bit(input logic [7:0] d, input int n, input int i);
      if (i == 0) return 1'b0;
      if (i <= n) return d[i-1];
      return 1'b1;
   endfunction

   task automatic chk(input int got, input int exp, input string req);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h at cycle %0d", req, got, exp, cyc);
      end
   endtask

   task automatic bw(input bit z, input int a, input int d);
      @(negedge clk);
      sel_a = !z; sel_z = z; bus_wr = 1'b1;
      bus_addr = 3'(a); bus_wdata = 8'(d);
      @(negedge clk);
      sel_a = 1'b0; sel_z = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic br(input bit z, input int a, output int d);
      sel_a = !z; sel_z = z; bus_addr = 3'(a);
      #1;
      d = z ? int'(rdata_z) : int'(rdata_a);
      sel_a = 1'b0; sel_z = 1'b0;
   endtask

   task automatic set_div(input bit z, input int dv, input int wl);
      bw(z, 3, 8'h80 | wl);
      bw(z, 0, dv & 8'hFF);
      bw(z, 1, (dv >> 8) & 8'hFF);
      bw(z, 3, wl);
   endtask

   task automatic wait_to(input int unsigned base, input int unsigned t);
      while (cyc - base < t) @(negedge clk);
   endtask

   task automatic find_start(output int unsigned base);
      int n = 0;
      while (txd_a !== 1'b0 && n < 4000) begin
         @(negedge clk);
         n++;
      end
      base = cyc;
   endtask

   task automatic check_frame(input int unsigned base, input logic [7:0] d, input int n,
                              input int b);
      for (int i = 0; i <= n + 1; i++) begin
         wait_to(base, i * b + b / 2);
         chk(txd_a, exp_bit(d, n, i), "R5 frame bit");
         if (i == 0) begin
            wait_to(base, b - 1);
            chk(txd_a, 0, "R6 start bit length");
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired (R1..R8 incomplete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int rd;
      int unsigned base;
      int unsigned seed;
      seed = 32'd2024;
      rd = $urandom(seed);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(txd_a, 1, "R1 idle line");
      br(0, 5, rd); chk(rd, 8'h20, "R1 status");
      br(0, 3, rd); chk(rd, 8'h00, "R1 line setup");
      bw(0, 3, 8'h80);
      br(0, 0, rd); chk(rd, 8'h00, "R1 divisor low");
      br(0, 1, rd); chk(rd, 8'h00, "R1 divisor high");

      // R2 divisor latch access
      bw(0, 0, 8'h41); bw(0, 1, 8'h03);
      br(0, 0, rd); chk(rd, 8'h41, "R2 divisor low");
      br(0, 1, rd); chk(rd, 8'h03, "R2 divisor high");
      br(0, 3, rd); chk(rd, 8'h80, "R4 setup readback");

      // R3 offsets remapped back
      bw(0, 3, 8'h03);
      bw(0, 1, 8'h77);
      br(0, 0, rd); chk(rd, 8'h00, "R3 data read");
      br(0, 1, rd); chk(rd, 8'h00, "R3 offset1 read");
      br(0, 5, rd); chk(rd, 8'h20, "R3 no byte loaded by offset1");
      chk(txd_a, 1, "R3 line idle");
      bw(0, 3, 8'h80);
      br(0, 1, rd); chk(rd, 8'h03, "R3 divisor high unchanged");
      br(0, 3, rd); chk(rd, 8'h80, "R4 setup readback");

      // R6 directed timing, divisor 1, 8 bits
      set_div(0, 1, 3);
      bw(0, 0, 8'hA5);
      br(0, 5, rd); chk(rd, 8'h00, "R4 status after write");
      chk(txd_a, 1, "R6 line before load");
      @(negedge clk);
      br(0, 5, rd); chk(rd, 8'h20, "R4 status after load");
      chk(txd_a, 0, "R6 start at second edge");
      base = cyc;
      check_frame(base, 8'hA5, 8, 16);
      wait_to(base, 10 * 16 - 1);
      chk(txd_a, 1, "R5 stop bit end");
      wait_to(base, 10 * 16 + 2);
      chk(txd_a, 1, "R5 idle after frame");

      // R8 back-to-back with overwrite
      set_div(0, 2, 3);
      bw(0, 0, 8'h3C);
      find_start(base);
      bw(0, 0, 8'h11);
      br(0, 5, rd); chk(rd, 8'h00, "R8 byte waiting");
      bw(0, 0, 8'hC6);
      check_frame(base, 8'h3C, 8, 32);
      wait_to(base, 10 * 32 - 1);
      chk(txd_a, 1, "R8 stop before next");
      wait_to(base, 10 * 32);
      chk(txd_a, 0, "R8 next start no gap");
      check_frame(base + 10 * 32, 8'hC6, 8, 32);

      // R5/R6 random frames
      for (int k = 0; k < 24; k++) begin
         int dv, wl;
         logic [7:0] d;
         dv = 1 + int'($urandom() % 3);
         wl = int'($urandom() % 4);
         d  = 8'($urandom());
         wait_to(base, 0);
         repeat (2) @(negedge clk);
         set_div(0, dv, wl);
         bw(0, 0, d);
         find_start(base);
         check_frame(base, d, 5 + wl, 16 * dv);
         wait_to(base, (7 + wl) * 16 * dv);
         chk(txd_a, 1, "R5 idle after random frame");
      end

      // R7 divisor zero on oversample-1 instance
      set_div(1, 0, 3);
      bw(1, 0, 8'h01);
      @(negedge clk);
      chk(txd_z, 0, "R7 start bit");
      base = cyc;
      wait_to(base, 65535);
      chk(txd_z, 0, "R7 start lasts 65536");
      wait_to(base, 65536);
      chk(txd_z, 1, "R7 first data bit after 65536");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule